// File: doc/BRIEF.md
# Window Watchdog with Warm-Boot Flag

This block supervises an external controller by requiring it to rewrite a watchdog enable bit inside a time window. Until the enable bit is written with 1, the block stays idle. After that, a free-running cycle counter measures the time since the last accepted write. A rewrite of 1 is only accepted when the counter sits inside the window, which is at least the minimum count and below the timeout count. Such a rewrite restarts the counter at zero.

A rewrite that arrives too early is a fault. A counter that reaches the last count in the window with no write is also a fault. Either fault drives the shared active-low reset output low for a fixed number of cycles. The same fault sets a sticky status bit, so that software running after the restart can tell a warm boot from a cold one. Software clears this bit with a read strobe.

The counter resumes from zero after the pulse, and the watchdog stays armed. An asynchronous hard reset returns everything to the idle, disabled state.

Top module: `wdog_window`

## Requirements
- R1: After hard reset the watchdog is disabled. `wd_rst_n_o` is 1 and `warm_boot_o` is 0. While disabled, no reset pulse is ever produced.
- R2: A write strobe (`en_wr_i`=1) with `en_val_i`=1 enables the watchdog. The counter reads 0 in the cycle after that write edge and then rises by one per cycle.
- R3: While enabled, a write of 1 seen at a counter value c with MIN_CYC <= c < TMO_CYC is accepted. It produces no pulse and restarts the counter at 0.
- R4: While enabled, a write of 1 seen at a counter value below MIN_CYC is an early fault. `wd_rst_n_o` is 0 in the cycle after that edge.
- R5: While enabled, if no write is seen when the counter is at TMO_CYC-1, this is a timeout fault. `wd_rst_n_o` is 0 in the cycle after that edge.
- R6: After any fault, `wd_rst_n_o` stays 0 for exactly PULSE_CYC consecutive cycles and then returns to 1.
- R7: `warm_boot_o` becomes 1 in the same cycle that `wd_rst_n_o` first goes low.
- R8: After the pulse ends, the watchdog is still enabled and the counter is 0 in the first cycle with `wd_rst_n_o`=1. An unkicked run therefore faults again TMO_CYC cycles later.
- R9: A read strobe (`boot_rd_i`=1) clears `warm_boot_o` on the next edge. If a fault and a read strobe fall on the same edge, the flag ends up set.
- R10: Writes that arrive while `wd_rst_n_o` is 0 are ignored. This holds for writes of 0 and writes of 1.
- R11: A write with `en_val_i`=0 disables the watchdog and clears the counter. No pulse follows, and a later write of 1 starts a fresh window from 0.
- R12: `hard_rst_i`=1 asynchronously forces `wd_rst_n_o` to 1 and `warm_boot_o` to 0, and disables the watchdog. This applies even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| hard_rst_i | input | 1 | Asynchronous hard reset, active high |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_val_i | input | 1 | Value written to the enable bit |
| boot_rd_i | input | 1 | Read strobe that clears the warm-boot flag |
| wd_rst_n_o | output | 1 | Active-low reset pulse output |
| warm_boot_o | output | 1 | Sticky flag: the last restart was caused by the watchdog |

## Verification
The main instance uses MIN_CYC=8, TMO_CYC=20 and PULSE_CYC=4. With these values every window edge can be hit by cycle-exact kicks: counts 7, 8 and 19, and the silent run out to 19. A four-cycle pulse leaves room to inject writes and a hard reset in the middle of a pulse. A second instance with PULSE_CYC=1 builds the single-flop pulse variant, and the bench checks that its pulse lasts exactly one cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // Classification of the write activity seen in one cycle
   typedef enum logic [2:0] {
      WK_IDLE  = 3'd0,   // no write, counter not at its last value
      WK_GOOD  = 3'd1,   // write of 1 inside the window
      WK_EARLY = 3'd2,   // write of 1 before the window opens
      WK_LATE  = 3'd3,   // no write at the last count of the window
      WK_STOP  = 3'd4    // write of 0, disables the watchdog
   } kick_e;

   function automatic logic wk_is_fault(kick_e k);
      return (k == WK_EARLY) || (k == WK_LATE);
   endfunction

   function automatic logic wk_restarts(kick_e k);
      return k != WK_IDLE;
   endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg (
   input  logic clk_i,
   input  logic hard_rst_i,
   input  logic wr_i,
   input  logic wr_val_i,
   input  logic hold_i,
   output logic en_o
);

   logic en_q;

   always_ff @(posedge clk_i or posedge hard_rst_i) begin
      if (hard_rst_i) begin
         en_q <= 1'b0;
      end else if (wr_i && !hold_i) begin
         en_q <= wr_val_i;
      end
   end

   assign en_o = en_q;

endmodule

// File: rtl/wdog_win_timer.sv
module wdog_win_timer
   import wdog_pkg::*;
#(
   parameter int MIN_CYC = 1000,
   parameter int TMO_CYC = 4000,
   parameter int CNT_W   = $clog2(TMO_CYC)
) (
   input  logic             clk_i,
   input  logic             hard_rst_i,
   input  logic             en_i,
   input  logic             hold_i,
   input  logic             wr_i,
   input  logic             wr_val_i,
   output logic             fault_o,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] MinV  = CNT_W'(MIN_CYC);
   localparam logic [CNT_W-1:0] LastV = CNT_W'(TMO_CYC - 1);

   logic [CNT_W-1:0] cnt_q;
   kick_e            kind;

   always_comb begin
      kind = WK_IDLE;
      if (wr_i && !wr_val_i) begin
         kind = WK_STOP;
      end else if (wr_i) begin
         kind = (cnt_q < MinV) ? WK_EARLY : WK_GOOD;
      end else if (cnt_q == LastV) begin
         kind = WK_LATE;
      end
   end

   assign fault_o = en_i && !hold_i && wk_is_fault(kind);

   always_ff @(posedge clk_i or posedge hard_rst_i) begin
      if (hard_rst_i) begin
         cnt_q <= '0;
      end else if (!en_i || hold_i || wk_restarts(kind)) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
   parameter int PULSE_CYC = 16
) (
   input  logic clk_i,
   input  logic hard_rst_i,
   input  logic fire_i,
   output logic active_o
);

   generate
      if (PULSE_CYC == 1) begin : g_single
         logic act_q;
         always_ff @(posedge clk_i or posedge hard_rst_i) begin
            if (hard_rst_i) act_q <= 1'b0;
            else            act_q <= fire_i;
         end
         assign active_o = act_q;
      end else begin : g_count
         localparam int PW = $clog2(PULSE_CYC + 1);
         logic [PW-1:0] left_q;
         always_ff @(posedge clk_i or posedge hard_rst_i) begin
            if (hard_rst_i) begin
               left_q <= '0;
            end else if (fire_i) begin
               left_q <= PW'(PULSE_CYC);
            end else if (left_q != '0) begin
               left_q <= left_q - 1'b1;
            end
         end
         assign active_o = (left_q != '0);
      end
   endgenerate

endmodule

// File: rtl/wdog_boot_flag.sv
module wdog_boot_flag (
   input  logic clk_i,
   input  logic hard_rst_i,
   input  logic set_i,
   input  logic rd_i,
   output logic warm_o
);

   logic warm_q;

   always_ff @(posedge clk_i or posedge hard_rst_i) begin
      if (hard_rst_i)  warm_q <= 1'b0;
      else if (set_i)  warm_q <= 1'b1;
      else if (rd_i)   warm_q <= 1'b0;
   end

   assign warm_o = warm_q;

endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
   parameter int MIN_CYC   = 1000,
   parameter int TMO_CYC   = 4000,
   parameter int PULSE_CYC = 16
) (
   input  logic clk_i,
   input  logic hard_rst_i,
   input  logic en_wr_i,
   input  logic en_val_i,
   input  logic boot_rd_i,
   output logic wd_rst_n_o,
   output logic warm_boot_o
);

   localparam int CNT_W = $clog2(TMO_CYC);

   generate
      if (MIN_CYC < 1 || MIN_CYC >= TMO_CYC) begin : g_bad_window
         $error("wdog_window: need 1 <= MIN_CYC < TMO_CYC");
      end
      if (TMO_CYC < 2) begin : g_bad_tmo
         $error("wdog_window: TMO_CYC must be at least 2");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("wdog_window: PULSE_CYC must be at least 1");
      end
   endgenerate

   logic             en_q;
   logic             pulse_on;
   logic             fault;
   logic [CNT_W-1:0] tmr_cnt;

   wdog_ctrl_reg u_ctrl (
      .clk_i      (clk_i),
      .hard_rst_i (hard_rst_i),
      .wr_i       (en_wr_i),
      .wr_val_i   (en_val_i),
      .hold_i     (pulse_on),
      .en_o       (en_q)
   );

   wdog_win_timer #(
      .MIN_CYC (MIN_CYC),
      .TMO_CYC (TMO_CYC),
      .CNT_W   (CNT_W)
   ) u_timer (
      .clk_i      (clk_i),
      .hard_rst_i (hard_rst_i),
      .en_i       (en_q),
      .hold_i     (pulse_on),
      .wr_i       (en_wr_i),
      .wr_val_i   (en_val_i),
      .fault_o    (fault),
      .cnt_o      (tmr_cnt)
   );

   wdog_rst_pulse #(
      .PULSE_CYC (PULSE_CYC)
   ) u_pulse (
      .clk_i      (clk_i),
      .hard_rst_i (hard_rst_i),
      .fire_i     (fault),
      .active_o   (pulse_on)
   );

   wdog_boot_flag u_flag (
      .clk_i      (clk_i),
      .hard_rst_i (hard_rst_i),
      .set_i      (fault),
      .rd_i       (boot_rd_i),
      .warm_o     (warm_boot_o)
   );

   assign wd_rst_n_o = !pulse_on;

endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk #(
   parameter int MIN_CYC   = 1000,
   parameter int TMO_CYC   = 4000,
   parameter int PULSE_CYC = 16,
   parameter int CNT_W     = $clog2(TMO_CYC)
) (
   input logic             clk_i,
   input logic             hard_rst_i,
   input logic             wr_i,
   input logic             wr_val_i,
   input logic             rd_i,
   input logic             rst_n_i,
   input logic             warm_i,
   input logic             en_i,
   input logic [CNT_W-1:0] cnt_i
);

   localparam int LW = $clog2(PULSE_CYC + 2);
   localparam logic [CNT_W-1:0] MinV  = CNT_W'(MIN_CYC);
   localparam logic [CNT_W-1:0] LastV = CNT_W'(TMO_CYC - 1);
   localparam logic [LW-1:0]    PulV  = LW'(PULSE_CYC);

   // counts consecutive low cycles of the reset output
   logic [LW-1:0] lowc;
   always_ff @(posedge clk_i or posedge hard_rst_i) begin
      if (hard_rst_i)    lowc <= '0;
      else if (!rst_n_i) lowc <= lowc + 1'b1;
      else               lowc <= '0;
   end

   p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      (!en_i && rst_n_i) |=> rst_n_i);

   p_good_kick_r3: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      (en_i && rst_n_i && wr_i && wr_val_i && cnt_i >= MinV) |=> (rst_n_i && cnt_i == '0));

   p_early_kick_r4: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      (en_i && rst_n_i && wr_i && wr_val_i && cnt_i < MinV) |=> !rst_n_i);

   p_timeout_r5: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      (en_i && rst_n_i && !wr_i && cnt_i == LastV) |=> !rst_n_i);

   p_cnt_range_r5: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      cnt_i <= LastV);

   p_pulse_len_r6: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      $rose(rst_n_i) |-> (lowc == PulV));

   p_warm_set_r7: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      $fell(rst_n_i) |-> warm_i);

   p_restart_r8: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      $rose(rst_n_i) |-> (en_i && cnt_i == '0));

   p_read_clear_r9: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      (rd_i && !en_i && rst_n_i) |=> !warm_i);

   p_hold_en_r10: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      !rst_n_i |=> $stable(en_i));

   p_stop_r11: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      (rst_n_i && wr_i && !wr_val_i) |=> (!en_i && cnt_i == '0));

endmodule

bind wdog_window wdog_window_chk #(
   .MIN_CYC   (MIN_CYC),
   .TMO_CYC   (TMO_CYC),
   .PULSE_CYC (PULSE_CYC)
) chk_i (
   .clk_i      (clk_i),
   .hard_rst_i (hard_rst_i),
   .wr_i       (en_wr_i),
   .wr_val_i   (en_val_i),
   .rd_i       (boot_rd_i),
   .rst_n_i    (wd_rst_n_o),
   .warm_i     (warm_boot_o),
   .en_i       (en_q),
   .cnt_i      (tmr_cnt)
);

// File: tb/wdog_window_tb_top.sv
module wdog_window_tb_top;

   localparam int MIN = 8;
   localparam int TMO = 20;
   localparam int PUL = 4;

   logic clk = 1'b0;
   logic hrst = 1'b1;
   logic wr1 = 1'b0, val1 = 1'b0, rd1 = 1'b0;
   logic wr2 = 1'b0, val2 = 1'b0;
   logic rstn1, warm1, rstn2, warm2;

   int n_chk = 0;
   int n_bad = 0;
   int lows1 = 0;

   always #2 clk = ~clk;

   wdog_window #(.MIN_CYC(MIN), .TMO_CYC(TMO), .PULSE_CYC(PUL)) dut_i (
      .clk_i(clk), .hard_rst_i(hrst), .en_wr_i(wr1), .en_val_i(val1),
      .boot_rd_i(rd1), .wd_rst_n_o(rstn1), .warm_boot_o(warm1));

   wdog_window #(.MIN_CYC(MIN), .TMO_CYC(TMO), .PULSE_CYC(1)) dut1c_i (
      .clk_i(clk), .hard_rst_i(hrst), .en_wr_i(wr2), .en_val_i(val2),
      .boot_rd_i(1'b0), .wd_rst_n_o(rstn2), .warm_boot_o(warm2));

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // advance n falling edges, counting low samples of the main reset output
   task automatic adv(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!rstn1) lows1++;
      end
   endtask

   task automatic wr_main(logic v);
      wr1 = 1'b1; val1 = v;
      @(negedge clk);
      wr1 = 1'b0; val1 = 1'b0;
   endtask

   task automatic hard_reset();
      hrst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      hrst = 1'b0;
      @(negedge clk);
      lows1 = 0;
   endtask

   task automatic wait_high();
      for (int i = 0; i < 100 && !rstn1; i++) @(negedge clk);
   endtask

   task automatic t_reset_idle();
      hard_reset();
      chk("R1 reset level", rstn1, 1);
      chk("R1 reset flag", warm1, 0);
      adv(3 * TMO);
      chk("R1 idle no pulse", lows1, 0);
   endtask

   task automatic t_window_edges();
      hard_reset();
      wr_main(1'b1);
      adv(MIN);
      wr_main(1'b1);                 // kick at count MIN
      chk("R3 kick at MIN", rstn1, 1);
      adv(TMO - 1);
      wr_main(1'b1);                 // kick at count TMO-1
      chk("R3 kick at TMO-1", rstn1, 1);
      adv(12);
      wr_main(1'b1);
      adv(TMO - 1);
      chk("R3 window restarted", lows1, 0);
      adv(1);
      chk("R5 timeout after last kick", rstn1, 0);
      wait_high();
   endtask

   task automatic t_early();
      int low;
      hard_reset();
      wr_main(1'b1);
      adv(MIN - 1);
      wr_main(1'b1);                 // kick at count MIN-1
      chk("R4 early kick pulse", rstn1, 0);
      chk("R7 warm set with pulse", warm1, 1);
      low = 0;
      while (!rstn1 && low < 100) begin low++; @(negedge clk); end
      chk("R6 pulse length", low, PUL);
      lows1 = 0;
      adv(TMO - 1);
      chk("R8 armed after pulse, quiet", lows1, 0);
      adv(1);
      chk("R8 second timeout", rstn1, 0);
      wait_high();
   endtask

   task automatic t_late_and_read();
      hard_reset();
      wr_main(1'b1);
      adv(TMO - 1);
      chk("R2 enabled quiet window", lows1, 0);
      adv(1);
      chk("R5 timeout pulse", rstn1, 0);
      wait_high();
      chk("R7 flag after timeout", warm1, 1);
      rd1 = 1'b1; @(negedge clk); rd1 = 1'b0;
      chk("R9 read clears", warm1, 0);
   endtask

   task automatic t_read_collide();
      hard_reset();
      wr_main(1'b1);
      adv(MIN - 1);
      wr1 = 1'b1; val1 = 1'b1; rd1 = 1'b1;
      @(negedge clk);
      wr1 = 1'b0; val1 = 1'b0; rd1 = 1'b0;
      chk("R9 set wins over read", warm1, 1);
      wait_high();
   endtask

   task automatic t_ignore_in_pulse();
      hard_reset();
      wr_main(1'b1);
      adv(2);
      wr_main(1'b1);                 // early fault
      wr_main(1'b0);                 // during pulse, must be ignored
      wr_main(1'b1);                 // during pulse, must be ignored
      wait_high();
      lows1 = 0;
      adv(TMO - 1);
      chk("R10 still armed, quiet", lows1, 0);
      adv(1);
      chk("R10 write 0 in pulse ignored", rstn1, 0);
      wait_high();
   endtask

   task automatic t_disable();
      hard_reset();
      wr_main(1'b1);
      adv(TMO - 2);
      wr_main(1'b0);
      adv(3 * TMO);
      chk("R11 disabled no pulse", lows1, 0);
      chk("R11 disabled flag", warm1, 0);
      wr_main(1'b1);
      adv(TMO - 1);
      chk("R11 fresh window", lows1, 0);
      adv(1);
      chk("R11 timeout from fresh window", rstn1, 0);
   endtask

   task automatic t_hard_mid_pulse();
      hard_reset();
      wr_main(1'b1);
      adv(1);
      wr_main(1'b1);
      adv(1);
      chk("R12 in pulse", rstn1, 0);
      hrst = 1'b1;
      #1;
      chk("R12 reset releases output", rstn1, 1);
      chk("R12 reset clears flag", warm1, 0);
      @(negedge clk);
      hrst = 1'b0;
      lows1 = 0;
      adv(3 * TMO);
      chk("R12 disabled after reset", lows1, 0);
   endtask

   task automatic t_single_pulse();
      int low;
      hard_reset();
      wr2 = 1'b1; val2 = 1'b1; @(negedge clk); wr2 = 1'b0;
      repeat (3) @(negedge clk);
      wr2 = 1'b1; val2 = 1'b1; @(negedge clk); wr2 = 1'b0; val2 = 1'b0;
      chk("R4 early fault, 1-cycle variant", rstn2, 0);
      chk("R7 flag, 1-cycle variant", warm2, 1);
      low = 0;
      while (!rstn2 && low < 100) begin low++; @(negedge clk); end
      chk("R6 pulse length 1", low, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset_idle();
      t_window_edges();
      t_early();
      t_late_and_read();
      t_read_collide();
      t_ignore_in_pulse();
      t_disable();
      t_hard_mid_pulse();
      t_single_pulse();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule